// File: doc/BRIEF.md
# Paged Program Counter

This block holds the instruction address of a small controller core. Each cycle it does one of four things: it keeps its value, steps forward by one, takes a jump target, or returns to zero. A jump target has only the low address bits. The top two address bits come from a page field inside a separate high-address latch byte. The rest of that byte plays no part.

Stepping does not run freely through the low range. Once the count reaches a fixed ceiling value, further steps leave it there. A count above the ceiling can only come from a paged jump, and it steps on normally. The low byte of the count is held in its own register next to the count. Both register-bank views of the low-byte location read from that one copy, so the two views always agree with the count.

Top module: `prog_counter`

## Requirements
- R1: While `srst` is high at a clock edge, the next `count_o` and `low_o` are both zero.
- R2: When `inc_en` is high, `load_en` is low and `count_o` is not 0x3FF, the count after the edge is the old count plus one.
- R3: When `inc_en` is high, `load_en` is low and `count_o` equals 0x3FF, the count does not change.
- R4: When `load_en` is high, the count after the edge is `{latch_hi[4:3], load_tgt[10:0]}`: latch bit 4 goes to count bit 12, and latch bit 3 goes to count bit 11.
- R5: The bits of `latch_hi` other than bits 4:3 have no effect on a load.
- R6: When `load_en` and `inc_en` are both high, the load is taken and the increment is ignored.
- R7: `srst` overrides both `load_en` and `inc_en`.
- R8: After every clock edge, `low_o` equals `count_o[7:0]`.
- R9: With no strobe high, the count holds, whatever `load_tgt` and `latch_hi` carry.
- R10: A count above 0x3FF increments normally, and 0x1FFF steps to 0x0000.
- R11: `latch_hi` has no effect on an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| inc_en | input | 1 | Step the count by one |
| load_en | input | 1 | Take a jump target |
| load_tgt | input | 11 | Low bits of the jump target |
| latch_hi | input | 8 | High-address latch byte; bits 4:3 are the page |
| count_o | output | 13 | Current count |
| low_o | output | 8 | Registered low byte of the count |

## Verification
The bench builds the block with its default sizes: a 13-bit count, an 11-bit target, an 8-bit latch and a ceiling of 0x3FF. These are small enough to sweep completely. Every target is loaded under all four page values, with the unused latch bits and the increment strobe changing along with the target. Every increment from zero up to the ceiling is checked. Directed sequences cover holding at the ceiling, stepping above it, wrapping at the top of the 13-bit range, and reset taking priority over both strobes.

// File: rtl/prog_counter_pkg.sv
package prog_counter_pkg;
    typedef enum logic [1:0] {
        PC_OP_HOLD  = 2'd0,
        PC_OP_STEP  = 2'd1,
        PC_OP_LOAD  = 2'd2,
        PC_OP_CLEAR = 2'd3
    } pc_op_e;
endpackage

// File: rtl/pc_op_sel.sv
module pc_op_sel
    import prog_counter_pkg::*;
(
    input  logic   clear,
    input  logic   load,
    input  logic   step,
    output pc_op_e op
);
    always_comb begin
        if (clear)      op = PC_OP_CLEAR;
        else if (load)  op = PC_OP_LOAD;
        else if (step)  op = PC_OP_STEP;
        else            op = PC_OP_HOLD;
    end
endmodule

// File: rtl/pc_page_merge.sv
module pc_page_merge #(
    parameter int PC_W    = 13,
    parameter int TGT_W   = 11,
    parameter int HI_W    = 8,
    parameter int PAGE_LO = 3
) (
    input  logic [TGT_W-1:0] tgt,
    input  logic [HI_W-1:0]  hi,
    output logic [PC_W-1:0]  dest
);
    localparam int PAGE_W = PC_W - TGT_W;

    generate
        if (PAGE_W > 0) begin : g_paged
            assign dest = {hi[PAGE_LO +: PAGE_W], tgt};
        end else begin : g_flat
            assign dest = tgt[PC_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pc_step.sv
module pc_step #(
    parameter int PC_W = 13,
    parameter int CEIL = 'h3FF
) (
    input  logic [PC_W-1:0] cur,
    output logic [PC_W-1:0] nxt
);
    localparam logic [PC_W-1:0] CEIL_V = PC_W'(CEIL);

    always_comb begin
        if (cur == CEIL_V) nxt = cur;
        else               nxt = cur + PC_W'(1);
    end
endmodule

// File: rtl/prog_counter.sv
module prog_counter
    import prog_counter_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int TGT_W   = 11,
    parameter int HI_W    = 8,
    parameter int PAGE_LO = 3,
    parameter int LOW_W   = 8,
    parameter int CEIL    = 'h3FF
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             inc_en,
    input  logic             load_en,
    input  logic [TGT_W-1:0] load_tgt,
    input  logic [HI_W-1:0]  latch_hi,
    output logic [PC_W-1:0]  count_o,
    output logic [LOW_W-1:0] low_o
);
    typedef struct packed {
        logic [PC_W-1:0]  cnt;
        logic [LOW_W-1:0] low;
    } pc_state_t;

    pc_state_t        state_d, state_q;
    pc_op_e           op;
    logic [PC_W-1:0]  jump_dest;
    logic [PC_W-1:0]  step_val;
    logic [PC_W-1:0]  cnt_next;

    pc_op_sel u_sel (
        .clear (srst),
        .load  (load_en),
        .step  (inc_en),
        .op    (op)
    );

    pc_page_merge #(
        .PC_W    (PC_W),
        .TGT_W   (TGT_W),
        .HI_W    (HI_W),
        .PAGE_LO (PAGE_LO)
    ) u_merge (
        .tgt  (load_tgt),
        .hi   (latch_hi),
        .dest (jump_dest)
    );

    pc_step #(
        .PC_W (PC_W),
        .CEIL (CEIL)
    ) u_step (
        .cur (state_q.cnt),
        .nxt (step_val)
    );

    always_comb begin
        unique case (op)
            PC_OP_CLEAR: cnt_next = '0;
            PC_OP_LOAD:  cnt_next = jump_dest;
            PC_OP_STEP:  cnt_next = step_val;
            default:     cnt_next = state_q.cnt;
        endcase
        state_d.cnt = cnt_next;
        state_d.low = cnt_next[LOW_W-1:0];
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count_o = state_q.cnt;
    assign low_o   = state_q.low;
endmodule

// File: rtl/prog_counter_chk.sv
module prog_counter_chk #(
    parameter int PC_W    = 13,
    parameter int TGT_W   = 11,
    parameter int HI_W    = 8,
    parameter int PAGE_LO = 3,
    parameter int LOW_W   = 8,
    parameter int CEIL    = 'h3FF
) (
    input logic             clk,
    input logic             srst,
    input logic             inc_en,
    input logic             load_en,
    input logic [TGT_W-1:0] load_tgt,
    input logic [HI_W-1:0]  latch_hi,
    input logic [PC_W-1:0]  count_o,
    input logic [LOW_W-1:0] low_o
);
    localparam int PAGE_W = PC_W - TGT_W;
    localparam logic [PC_W-1:0] CEIL_V = PC_W'(CEIL);

    AST_RESET_ZERO: assert property (@(posedge clk) srst |=> (count_o == '0 && low_o == '0)); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (srst)
        (inc_en && !load_en && count_o != CEIL_V) |=> count_o == $past(count_o) + PC_W'(1)); // R2
    AST_CEIL_HOLD: assert property (@(posedge clk) disable iff (srst)
        (inc_en && !load_en && count_o == CEIL_V) |=> $stable(count_o)); // R3
    AST_PAGED_LOAD: assert property (@(posedge clk) disable iff (srst)
        load_en |=> count_o == {$past(latch_hi[PAGE_LO +: PAGE_W]), $past(load_tgt)}); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (srst)
        (!inc_en && !load_en) |=> $stable(count_o)); // R9
    AST_LOW_MIRROR: assert property (@(posedge clk) disable iff (srst)
        1'b1 |-> low_o == count_o[LOW_W-1:0]); // R8
endmodule

bind prog_counter prog_counter_chk #(
    .PC_W    (PC_W),
    .TGT_W   (TGT_W),
    .HI_W    (HI_W),
    .PAGE_LO (PAGE_LO),
    .LOW_W   (LOW_W),
    .CEIL    (CEIL)
) chk_i (
    .clk      (clk),
    .srst     (srst),
    .inc_en   (inc_en),
    .load_en  (load_en),
    .load_tgt (load_tgt),
    .latch_hi (latch_hi),
    .count_o  (count_o),
    .low_o    (low_o)
);

// File: tb/prog_counter_tb_top.sv
module prog_counter_tb_top;
    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        inc_en = 1'b0;
    logic        load_en = 1'b0;
    logic [10:0] load_tgt = '0;
    logic [7:0]  latch_hi = '0;
    logic [12:0] count_o;
    logic [7:0]  low_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [12:0] exp_cnt = '0;

    always #4 clk = ~clk;

    prog_counter dut_i (
        .clk      (clk),
        .srst     (srst),
        .inc_en   (inc_en),
        .load_en  (load_en),
        .load_tgt (load_tgt),
        .latch_hi (latch_hi),
        .count_o  (count_o),
        .low_o    (low_o)
    );

    task automatic drive(input logic r, input logic i, input logic l,
                         input logic [10:0] t, input logic [7:0] h);
        srst = r; inc_en = i; load_en = l; load_tgt = t; latch_hi = h;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req);
        checks++;
        if (count_o !== exp_cnt) begin
            failures++;
            $display("FAIL %s count actual=%h expected=%h", req, count_o, exp_cnt);
        end
        checks++;
        if (low_o !== exp_cnt[7:0]) begin
            failures++;
            $display("FAIL R8 low actual=%h expected=%h", low_o, exp_cnt[7:0]);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        drive(1, 0, 0, '0, '0);
        drive(1, 0, 0, '0, '0);
        exp_cnt = '0;
        check("R1");

        // R2 / R11: step from zero up to the ceiling with varying latch
        for (int k = 0; k < 'h3FF; k++) begin
            drive(0, 1, 0, 11'(k * 7), 8'(k));
            exp_cnt = exp_cnt + 13'd1;
            check("R2_R11");
        end

        // R3: hold at the ceiling
        for (int k = 0; k < 4; k++) begin
            drive(0, 1, 0, '0, 8'hFF);
            check("R3");
        end

        // R9: no strobe, inputs busy
        for (int k = 0; k < 4; k++) begin
            drive(0, 0, 0, 11'h555 + 11'(k), 8'h18);
            check("R9");
        end

        // R4 / R5 / R6: every target under every page
        for (int pg = 0; pg < 4; pg++) begin
            for (int t = 0; t < 2048; t++) begin
                logic [10:0] tv;
                logic [1:0]  pv;
                tv = 11'(t);
                pv = 2'(pg);
                drive(0, tv[0], 1, tv, {tv[2:0], pv, tv[5:3]});
                exp_cnt = {pv, tv};
                check("R4_R5_R6");
            end
        end

        // R10: step above the ceiling and wrap at the top
        drive(0, 0, 1, 11'h400, 8'h00);
        exp_cnt = 13'h0400;
        check("R4");
        drive(0, 1, 0, '0, '0);
        exp_cnt = 13'h0401;
        check("R10");
        drive(0, 0, 1, 11'h7FE, 8'h18);
        exp_cnt = 13'h1FFE;
        check("R4");
        drive(0, 1, 0, '0, '0);
        exp_cnt = 13'h1FFF;
        check("R10");
        drive(0, 1, 0, '0, '0);
        exp_cnt = 13'h0000;
        check("R10");
        drive(0, 1, 0, '0, '0);
        exp_cnt = 13'h0001;
        check("R10");

        // R7: reset beats load and increment
        drive(0, 0, 1, 11'h3FE, 8'h08);
        exp_cnt = 13'h0BFE;
        check("R4");
        drive(1, 1, 1, 11'h123, 8'h18);
        exp_cnt = '0;
        check("R7");

        // R3 again: approach the ceiling by loading
        drive(0, 0, 1, 11'h3FE, 8'h00);
        exp_cnt = 13'h03FE;
        check("R4");
        drive(0, 1, 0, '0, '0);
        exp_cnt = 13'h03FF;
        check("R2");
        drive(0, 1, 0, '0, 8'h18);
        check("R3");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule